// File: doc/BRIEF.md
# Three-Lane Serial-to-Parallel Link Receiver

This block turns three serial data lanes back into one 21-bit parallel word. A fourth lane carries a forwarded framing clock that sits high for four bit slots and low for three in every word period. Everything runs on a sampling clock at seven times the word rate, which is an input to the block. On each sampling edge the block takes one bit from every lane and one sample of the framing clock. The slot in which the sampled framing clock goes from low to high is slot 0 of a new word.

After the seventh slot, the captured word is loaded into the output register. A strobe output rises with each new word, but only once the receiver is locked. Lock is granted after a run of correctly shaped framing periods. It is withdrawn when a period is malformed, when the framing clock stops, or when the receiver is put to sleep. While asleep, every output is held low. When the framing clock stops, the last word stays on the output and the strobe goes quiet.

Top module: `lane_deser_rx`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `word_o`, `strobe_o` and `locked_o` are all 0.
- R2: A word period starts in the sampling cycle where `fclk_ser` is 1 and was 0 in the cycle before; that cycle is slot 0. The bit of lane k in slot s (s = 0..6) goes to `word_o[7k+s]`. `word_o` takes the new word at the sampling edge after the one that captured slot 6.
- R3: A period is well formed when it has exactly seven slots and its `fclk_ser` samples are 1,1,1,1,0,0,0 in slot order. The rising transition that starts the next period judges the period just ended.
- R4: `strobe_o` rises in the same cycle that `word_o` takes a word, and only if `locked_o` was already 1 before that edge. It then stays high for four sampling cycles and is low for the remaining three.
- R5: `locked_o` goes to 1 at the rising `fclk_ser` transition that closes the LOCK_PERIODS-th consecutive well-formed period. A malformed period clears it at the transition that ends that period.
- R6: If no `fclk_ser` transition is sampled for LOSS_CYCLES consecutive cycles, `locked_o` drops. `word_o` keeps its last value and `strobe_o` stays low. A gap shorter than LOSS_CYCLES has no effect on `locked_o`.
- R7: While `sleep_n` is 0, `word_o`, `strobe_o` and `locked_o` are 0 from the next edge on. Once `sleep_n` returns to 1, lock has to be earned again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_7x | input | 1 | Sampling clock, seven edges per word period |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_n | input | 1 | Active-low power-down |
| fclk_ser | input | 1 | Forwarded framing clock, one sample per edge |
| lane_ser | input | LANES | Serial data lanes, one bit per lane per edge |
| word_o | output | 7*LANES | Rebuilt parallel word |
| strobe_o | output | 1 | Output strobe; its rising edge marks a new word |
| locked_o | output | 1 | Framing lock; high when the output words are valid |

## Verification
Single-bit words are sent with the set bit at the first bit, a lane boundary and the last bit. These expose swapped lanes, reversed slot order and off-by-one slot counting. The all-ones word, the zero word and a long run of random words check that no bit is stuck or leaks between lanes. Framing patterns with three and with five high slots check that a wrong pattern breaks lock even though the word content is still captured. A framing clock that stops just short of and well beyond the loss limit separates a normal gap from true clock loss. A sleep spell in the middle of a locked stream shows the forced-low outputs and that lock has to be earned again.

// File: rtl/lrx_pkg.sv
// Shared constants for the three-lane link receiver.
// Assumes a framing clock of seven slots per word, with four high slots followed by three low slots.
package lrx_pkg;
    localparam int SLOTS      = 7;
    localparam int HIGH_SLOTS = 4;
    localparam int SLOT_W     = 3;
    typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/lrx_frame_track.sv
// Framing tracker. It finds word boundaries in the sampled framing clock, checks the
// shape of each period, keeps the lock count and spots a stopped clock.
// Assumes one framing-clock sample per sampling edge and LOSS_CYCLES > HIGH_SLOTS.
module lrx_frame_track
    import lrx_pkg::*;
#(
    parameter int LOCK_PERIODS = 4,
    parameter int LOSS_CYCLES  = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sleep_n,
    input  logic  fclk_in,
    output slot_t pos_o,
    output logic  pos_vld_o,
    output logic  locked_o,
    output logic  lost_o
);
    localparam int    CNT_W    = $clog2(LOCK_PERIODS + 1);
    localparam int    IDLE_W   = $clog2(LOSS_CYCLES + 1);
    localparam slot_t PAST_END = slot_t'(SLOTS);

    logic              fclk_q;
    slot_t             slot_q;
    logic              pat_ok_q;
    logic [CNT_W-1:0]  good_cnt_q;
    logic [IDLE_W-1:0] idle_q;
    logic              rise;
    logic              toggle;
    logic              expect_hi;
    logic              period_good;

    assign rise        = fclk_in & ~fclk_q;
    assign toggle      = fclk_in ^ fclk_q;
    assign pos_o       = rise ? '0 : slot_q;
    assign pos_vld_o   = rise | (slot_q != PAST_END);
    assign expect_hi   = (slot_q < slot_t'(HIGH_SLOTS));
    assign period_good = rise & (slot_q == PAST_END) & pat_ok_q;
    assign lost_o      = (idle_q == IDLE_W'(LOSS_CYCLES));
    assign locked_o    = (good_cnt_q == CNT_W'(LOCK_PERIODS));

    // Slot position and pattern check for the period in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fclk_q   <= 1'b0;
            slot_q   <= PAST_END;
            pat_ok_q <= 1'b0;
        end else begin
            fclk_q <= fclk_in;
            if (rise) begin
                slot_q   <= slot_t'(1);
                pat_ok_q <= 1'b1;
            end else if (slot_q != PAST_END) begin
                slot_q   <= slot_q + slot_t'(1);
                pat_ok_q <= pat_ok_q & (fclk_in == expect_hi);
            end else begin
                pat_ok_q <= 1'b0;
            end
        end
    end

    // Count of consecutive good periods, saturating at the lock threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !sleep_n || lost_o) begin
            good_cnt_q <= '0;
        end else if (rise) begin
            if (!period_good)
                good_cnt_q <= '0;
            else if (!locked_o)
                good_cnt_q <= good_cnt_q + CNT_W'(1);
        end
    end

    // Sampling cycles since the last framing-clock transition.
    always_ff @(posedge clk) begin
        if (!rst_n || toggle)
            idle_q <= '0;
        else if (!lost_o)
            idle_q <= idle_q + IDLE_W'(1);
    end

    assert_loss_unlocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |=> !locked_o);
    assert_lock_at_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(rise));
    assert_sleep_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> !locked_o);
endmodule

// File: rtl/lrx_lane_cap.sv
// Capture buffer for one lane. Each valid slot position writes its own bit of the buffer.
// Assumes the position comes from the framing tracker and is in range whenever vld is 1.
module lrx_lane_cap
    import lrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lane_in,
    input  slot_t            pos,
    input  logic             vld,
    output logic [SLOTS-1:0] bits_o
);
    for (genvar b = 0; b < SLOTS; b++) begin : g_bit
        // Store the lane bit when the current slot matches this bit position.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits_o[b] <= 1'b0;
            else if (vld && pos == slot_t'(b))
                bits_o[b] <= lane_in;
        end
    end
endmodule

// File: rtl/lrx_out_stage.sv
// Output register and strobe generator. It loads a finished word, sends a strobe
// pulse when locked, and forces everything low in power-down.
// Assumes done_i is a one-cycle pulse that comes at most once per seven cycles.
module lrx_out_stage
    import lrx_pkg::*;
#(
    parameter int WORD_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_n,
    input  logic              done_i,
    input  logic              locked_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] word_o,
    output logic              strobe_o
);
    localparam int HI_W = $clog2(HIGH_SLOTS + 1);

    logic [HI_W-1:0] hi_left_q;

    // Word load, strobe launch and strobe high-time count.
    always_ff @(posedge clk) begin
        if (!rst_n || !sleep_n) begin
            word_o    <= '0;
            strobe_o  <= 1'b0;
            hi_left_q <= '0;
        end else if (done_i) begin
            word_o    <= word_i;
            strobe_o  <= locked_i;
            hi_left_q <= locked_i ? HI_W'(HIGH_SLOTS - 1) : '0;
        end else if (hi_left_q != '0) begin
            hi_left_q <= hi_left_q - HI_W'(1);
        end else begin
            strobe_o <= 1'b0;
        end
    end

    assert_sleep_forces_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> (word_o == '0 && !strobe_o));
    assert_strobe_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_o) |-> ($past(locked_i) && $past(done_i)));
    assert_word_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_n && !done_i) |=> $stable(word_o));
endmodule

// File: rtl/lane_deser_rx.sv
// Three-lane link receiver top. It splits the framing-clock samples off to the tracker,
// runs one capture buffer per lane, and marks the end of each word for the output stage.
// Assumes clk_7x runs at seven times the word rate and each lane sample lands mid-bit.
module lane_deser_rx
    import lrx_pkg::*;
#(
    parameter int LANES        = 3,
    parameter int LOCK_PERIODS = 4,
    parameter int LOSS_CYCLES  = 16
) (
    input  logic                     clk_7x,
    input  logic                     rst_n,
    input  logic                     sleep_n,
    input  logic                     fclk_ser,
    input  logic [LANES-1:0]         lane_ser,
    output logic [LANES*SLOTS-1:0]   word_o,
    output logic                     strobe_o,
    output logic                     locked_o
);
    localparam int    WORD_W    = LANES * SLOTS;
    localparam slot_t LAST_SLOT = slot_t'(SLOTS - 1);

    slot_t                        pos;
    logic                         pos_vld;
    logic                         lost;
    logic                         done_q;
    logic [LANES-1:0][SLOTS-1:0]  lane_bits;
    logic [WORD_W-1:0]            word_cap;

    lrx_frame_track #(
        .LOCK_PERIODS (LOCK_PERIODS),
        .LOSS_CYCLES  (LOSS_CYCLES)
    ) u_track (
        .clk       (clk_7x),
        .rst_n     (rst_n),
        .sleep_n   (sleep_n),
        .fclk_in   (fclk_ser),
        .pos_o     (pos),
        .pos_vld_o (pos_vld),
        .locked_o  (locked_o),
        .lost_o    (lost)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lrx_lane_cap u_cap (
            .clk     (clk_7x),
            .rst_n   (rst_n),
            .lane_in (lane_ser[k]),
            .pos     (pos),
            .vld     (pos_vld),
            .bits_o  (lane_bits[k])
        );
    end

    assign word_cap = lane_bits;

    // Flag that the last slot of a word was captured on this edge.
    always_ff @(posedge clk_7x) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= pos_vld && (pos == LAST_SLOT);
    end

    lrx_out_stage #(
        .WORD_W (WORD_W)
    ) u_out (
        .clk      (clk_7x),
        .rst_n    (rst_n),
        .sleep_n  (sleep_n),
        .done_i   (done_q),
        .locked_i (locked_o),
        .word_i   (word_cap),
        .word_o   (word_o),
        .strobe_o (strobe_o)
    );

    assert_no_strobe_when_lost_R6: assert property (@(posedge clk_7x) disable iff (!rst_n)
        lost |=> !$rose(strobe_o));
endmodule

// File: tb/sim_lane_deser_rx.sv
module sim_lane_deser_rx;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 3;
    localparam int LOCK_N     = 4;
    localparam int LOSS_N     = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_n = 1'b1;
    logic        fclk_ser = 1'b0;
    logic [2:0]  lane_ser = '0;
    logic [20:0] word_o;
    logic        strobe_o;
    logic        locked_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int          run = 0;
    bit          prev_good = 0;
    bit          lock_prev = 0;
    logic [20:0] prev_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_deser_rx #(.LANES(LANES), .LOCK_PERIODS(LOCK_N), .LOSS_CYCLES(LOSS_N)) u0 (
        .clk_7x(clk), .rst_n(rst_n), .sleep_n(sleep_n), .fclk_ser(fclk_ser),
        .lane_ser(lane_ser), .word_o(word_o), .strobe_o(strobe_o), .locked_o(locked_o));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [20:0] rnd_word();
        return 21'($urandom() & 32'h1FFFFF);
    endfunction

    // Expected lock from the bench's own count of consecutive good periods (R5, R7).
    function automatic bit next_lock(input bit awake);
        if (!awake) run = 0;
        else if (prev_good) run = (run < LOCK_N) ? run + 1 : run;
        else run = 0;
        return run >= LOCK_N;
    endfunction

    // One period: slot s carries bit 7k+s on lane k, and the framing clock is high for nhigh slots.
    task automatic send_period(input logic [20:0] w, input int nhigh);
        bit exp_lock;
        exp_lock = next_lock(sleep_n);
        for (int s = 0; s < 7; s++) begin
            @(negedge clk);
            if (s == 1) begin
                check("R2 word", 32'(word_o), sleep_n ? 32'(prev_word) : 32'd0);
                check("R5 locked", 32'(locked_o), 32'(exp_lock));
                check("R4 strobe rise", 32'(strobe_o), 32'(sleep_n && lock_prev));
            end
            if (s == 4) check("R4 strobe high", 32'(strobe_o), 32'(sleep_n && lock_prev));
            if (s == 5) check("R4 strobe low", 32'(strobe_o), 32'd0);
            fclk_ser = (s < nhigh);
            for (int k = 0; k < LANES; k++) lane_ser[k] = w[7*k+s];
        end
        prev_word = w;
        prev_good = (nhigh == 4);
        lock_prev = exp_lock;
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1 word", 32'(word_o), 32'd0);
        check("R1 strobe", 32'(strobe_o), 32'd0);
        check("R1 locked", 32'(locked_o), 32'd0);
        rst_n = 1'b1;

        // R2 directed bit-position words while lock is being gained (R5).
        send_period(21'h000001, 4);
        send_period(21'h000080, 4);
        send_period(21'h100000, 4);
        send_period(21'h000040, 4);
        send_period(21'h1FFFFF, 4);
        send_period(21'h000000, 4);
        send_period(21'h004000, 4);
        check("R5 locked after warm-up", 32'(locked_o), 32'd1);

        for (int i = 0; i < 30; i++) send_period(rnd_word(), 4);

        // R3 malformed framing patterns break lock.
        send_period(rnd_word(), 3);
        send_period(rnd_word(), 4);
        for (int i = 0; i < 6; i++) send_period(rnd_word(), 4);
        send_period(rnd_word(), 5);
        for (int i = 0; i < 7; i++) send_period(rnd_word(), 4);

        // R6 stopped framing clock: a short gap keeps lock, a long one drops it.
        for (int j = 0; j < LOSS_N - 4; j++) begin
            @(negedge clk);
            fclk_ser = 1'b0;
            lane_ser = 3'($urandom());
        end
        @(negedge clk);
        check("R6 short gap keeps lock", 32'(locked_o), 32'd1);
        check("R6 word after gap", 32'(word_o), 32'(prev_word));
        for (int j = 0; j < 8; j++) @(negedge clk);
        check("R6 lock lost", 32'(locked_o), 32'd0);
        check("R6 word held", 32'(word_o), 32'(prev_word));
        check("R6 strobe quiet", 32'(strobe_o), 32'd0);
        prev_good = 0;
        lock_prev = 0;
        run = 0;
        for (int i = 0; i < 8; i++) send_period(rnd_word(), 4);

        // R7 power-down in the middle of a locked stream.
        sleep_n = 1'b0;
        for (int i = 0; i < 3; i++) send_period(rnd_word(), 4);
        sleep_n = 1'b1;
        for (int i = 0; i < 8; i++) send_period(rnd_word(), 4);
        @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule